// File: doc/BRIEF.md
# Paged Program Counter and Status Register

This block produces the 11-bit instruction address for a small 8-bit controller core. It also keeps the processor status byte. The address space is split into two pages of 1 K words each: page 0 covers 0x000–0x3FF and page 1 covers 0x400–0x7FF. A page-select bit in the status byte supplies address bit 10 whenever the core jumps, calls or writes the low byte of the counter.

Calls push the full 11-bit return address onto an 8-entry hardware stack. Returns restore that address exactly as it was saved, so execution comes back to the calling page whatever the page bit holds at that moment.

The status byte carries the following fields:
- a general-purpose bit;
- a segment-select bit, which is also exported on its own pin;
- the page-select bit;
- the time-out and power-down flags, which only the sleep, watchdog-clear and watchdog-timeout events can change;
- the zero, half-carry and carry flags from the ALU.

The decoder drives one-cycle control pulses. Outputs change on the clock edge after a pulse.

Top module: `pcs_paged_pc`

## Requirements
- R1: While reset is asserted, the PC is 0x000 and the status byte is 0x18. In that value bit 4 (time-out) and bit 3 (power-down) are 1 and all other bits are 0.
- R2: In a cycle with no jump, call, return or PC-low write, the PC advances by one. It wraps from 0x7FF to 0x000.
- R3: A jump or a call loads PC[9:0] from the 10-bit target and PC[10] from status bit 5 (the page-select bit).
- R4: A PC-low write loads PC[7:0] from the write data, clears PC[9:8] and loads PC[10] from status bit 5.
- R5: A call saves PC+1 (all 11 bits). A later return restores exactly that value, independent of the current page bit. A return does not modify status bit 5.
- R6: The return stack holds 8 entries. A ninth call overwrites the oldest entry, and the pointer wraps without any error indication. A return from an empty stack reads the wrapped entry, which is 0x000 straight after reset.
- R7: When several PC controls are pulsed together, return wins over call, call wins over jump, and jump wins over PC-low write. A call that loses to a return pushes nothing.
- R8: Status bit 4 (time-out) is cleared by a watchdog timeout, even when a sleep or watchdog-clear command arrives in the same cycle. Otherwise it is set by either command.
- R9: Status bit 3 (power-down) is set by watchdog-clear and cleared by sleep. When both commands arrive in the same cycle, watchdog-clear wins.
- R10: A status write updates bits 7, 6, 5 and 2..0 from the write data and leaves bits 4 and 3 unchanged. Output seg_sel_o always equals status bit 6.
- R11: An ALU flag update loads bit 2 (zero), bit 1 (half carry) and bit 0 (carry). A status write in the same cycle takes precedence over it.
- R12: A jump, call or PC-low write that coincides with a status write uses the page bit as it was before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| jmp_i | input | 1 | Jump pulse |
| call_i | input | 1 | Call pulse |
| ret_i | input | 1 | Return pulse (any return type) |
| pcl_wr_i | input | 1 | Write of the PC low byte |
| stat_wr_i | input | 1 | Write of the status byte |
| sleep_i | input | 1 | Sleep command |
| wdtc_i | input | 1 | Watchdog-clear command |
| wdt_to_i | input | 1 | Watchdog timeout event |
| tgt_i | input | 10 | Jump/call target within a page |
| wdata_i | input | 8 | Write data for PC low byte or status |
| alu_we_i | input | 1 | ALU flag update enable |
| alu_z_i | input | 1 | ALU zero result |
| alu_dc_i | input | 1 | ALU half carry |
| alu_c_i | input | 1 | ALU carry |
| pc_o | output | 11 | Current program counter |
| status_o | output | 8 | Status byte |
| seg_sel_o | output | 1 | Control-register segment select |

## Verification
A corrupted stack pointer or stack entry stays hidden until the next return. At that point it appears on pc_o one cycle after the return pulse, as an address other than the saved call site plus one. This is why the deep overflow and underflow sequences are the key tests. A wrong page bit or wrong flag-update priority appears on pc_o or status_o on the edge right after the offending pulse, so every scenario samples the outputs exactly one cycle after it drives them.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam int PC_W   = 11;
  localparam int TGT_W  = 10;
  localparam int DATA_W = 8;

  // status bit positions (decoded by neighbouring logic)
  localparam int ST_PAGE = 5;
  localparam int ST_SEG  = 6;
  localparam int ST_TO   = 4;
  localparam int ST_PD   = 3;
  localparam int ST_Z    = 2;
  localparam int ST_DC   = 1;
  localparam int ST_C    = 0;

  localparam logic [DATA_W-1:0] STATUS_RST = 8'h18;

  typedef enum logic [1:0] {
    SEL_INC    = 2'd0,
    SEL_RET    = 2'd1,
    SEL_BRANCH = 2'd2,
    SEL_PCL    = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/pcs_retstack.sv
module pcs_retstack #(
  parameter int DEPTH = 8,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] push_data_i,
  output logic [AW-1:0] top_o
);
  localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SP_W-1:0] sp_q, sp_d;
  logic [AW-1:0]   ent_q [DEPTH];
  logic [SP_W-1:0] rd_idx;

  always_comb begin
    sp_d = sp_q;
    if (pop_i)       sp_d = sp_q - 1'b1;
    else if (push_i) sp_d = sp_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sp_q <= '0;
    else        sp_q <= sp_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_ent
      logic          wr_en;
      logic [AW-1:0] ent_d;
      always_comb begin
        wr_en = push_i && !pop_i && (sp_q == SP_W'(gi));
        ent_d = wr_en ? push_data_i : ent_q[gi];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q[gi] <= '0;
        else        ent_q[gi] <= ent_d;
      end
    end
  endgenerate

  assign rd_idx = sp_q - 1'b1;
  assign top_o  = ent_q[rd_idx];

  // R6: pointer steps by exactly one and wraps
  a_r6_push_step: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |=> sp_q == $past(sp_q) + 1'b1);
  a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |=> sp_q == $past(sp_q) - 1'b1);
  // R5: a pushed value becomes the next top of stack
  a_r5_push_top: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |=> top_o == $past(push_data_i));
endmodule

// File: rtl/pcs_status.sv
module pcs_status
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sleep_i,
  input  logic              wdtc_i,
  input  logic              wdt_to_i,
  input  logic              alu_we_i,
  input  logic              alu_z_i,
  input  logic              alu_dc_i,
  input  logic              alu_c_i,
  output logic [DATA_W-1:0] status_o
);
  logic [DATA_W-1:0] st_q, st_d;
  logic              st_en;

  assign st_en = stat_wr_i | sleep_i | wdtc_i | wdt_to_i | alu_we_i;

  always_comb begin
    st_d = st_q;
    if (stat_wr_i) begin
      st_d[7]       = wdata_i[7];
      st_d[ST_SEG]  = wdata_i[ST_SEG];
      st_d[ST_PAGE] = wdata_i[ST_PAGE];
      st_d[ST_Z]    = wdata_i[ST_Z];
      st_d[ST_DC]   = wdata_i[ST_DC];
      st_d[ST_C]    = wdata_i[ST_C];
    end else if (alu_we_i) begin
      st_d[ST_Z]  = alu_z_i;
      st_d[ST_DC] = alu_dc_i;
      st_d[ST_C]  = alu_c_i;
    end
    if (wdt_to_i)              st_d[ST_TO] = 1'b0;
    else if (sleep_i | wdtc_i) st_d[ST_TO] = 1'b1;
    if (wdtc_i)                st_d[ST_PD] = 1'b1;
    else if (sleep_i)          st_d[ST_PD] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= STATUS_RST;
    else if (st_en) st_q <= st_d;
  end

  assign status_o = st_q;

  a_r8_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to_i |=> !status_o[ST_TO]);
  a_r8_to_set: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_i || wdtc_i) && !wdt_to_i |=> status_o[ST_TO]);
  a_r9_pd_set: assert property (@(posedge clk) disable iff (!rst_n)
    wdtc_i |=> status_o[ST_PD]);
  a_r9_pd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i && !wdtc_i |=> !status_o[ST_PD]);
  a_r10_keep_flags: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_i && !sleep_i && !wdtc_i && !wdt_to_i |=> $stable(status_o[ST_TO:ST_PD]));
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_i |=> status_o[ST_Z:ST_C] == $past(wdata_i[ST_Z:ST_C]));
endmodule

// File: rtl/pcs_pcgen.sv
module pcs_pcgen
  import pcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              pcl_wr_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              page_i,
  input  logic [PC_W-1:0]   pop_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [PC_W-1:0]   push_data_o
);
  localparam int HI_PAD = TGT_W - DATA_W;

  pc_sel_e         sel;
  logic [PC_W-1:0] pc_q, pc_d, pc_inc;

  always_comb begin
    if (ret_i)                sel = SEL_RET;
    else if (call_i || jmp_i) sel = SEL_BRANCH;
    else if (pcl_wr_i)        sel = SEL_PCL;
    else                      sel = SEL_INC;
  end

  assign pc_inc = pc_q + 1'b1;

  always_comb begin
    unique case (sel)
      SEL_RET:    pc_d = pop_data_i;
      SEL_BRANCH: pc_d = {page_i, tgt_i};
      SEL_PCL:    pc_d = {page_i, {HI_PAD{1'b0}}, wdata_i};
      default:    pc_d = pc_inc;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o        = pc_q;
  assign pop_o       = (sel == SEL_RET);
  assign push_o      = call_i && !ret_i;
  assign push_data_o = pc_inc;

  a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
    !jmp_i && !call_i && !ret_i && !pcl_wr_i |=> pc_q == $past(pc_q) + 1'b1);
  a_r3_branch: assert property (@(posedge clk) disable iff (!rst_n)
    (jmp_i || call_i) && !ret_i |=> pc_q == {$past(page_i), $past(tgt_i)});
  a_r4_pcl_write: assert property (@(posedge clk) disable iff (!rst_n)
    pcl_wr_i && !jmp_i && !call_i && !ret_i |=>
      pc_q == {$past(page_i), 2'b00, $past(wdata_i)});
  a_r7_ret_first: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |=> pc_q == $past(pop_data_i));
endmodule

// File: rtl/pcs_paged_pc.sv
module pcs_paged_pc
  import pcs_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              pcl_wr_i,
  input  logic              stat_wr_i,
  input  logic              sleep_i,
  input  logic              wdtc_i,
  input  logic              wdt_to_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              alu_we_i,
  input  logic              alu_z_i,
  input  logic              alu_dc_i,
  input  logic              alu_c_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [DATA_W-1:0] status_o,
  output logic              seg_sel_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic            push, pop;
  logic [PC_W-1:0] push_data, pop_data;
  logic [DATA_W-1:0] status;

  pcs_status u_status (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .stat_wr_i (stat_wr_i),
    .wdata_i   (wdata_i),
    .sleep_i   (sleep_i),
    .wdtc_i    (wdtc_i),
    .wdt_to_i  (wdt_to_i),
    .alu_we_i  (alu_we_i),
    .alu_z_i   (alu_z_i),
    .alu_dc_i  (alu_dc_i),
    .alu_c_i   (alu_c_i),
    .status_o  (status)
  );

  pcs_pcgen u_pcgen (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .jmp_i       (jmp_i),
    .call_i      (call_i),
    .ret_i       (ret_i),
    .pcl_wr_i    (pcl_wr_i),
    .tgt_i       (tgt_i),
    .wdata_i     (wdata_i),
    .page_i      (status[ST_PAGE]),
    .pop_data_i  (pop_data),
    .pc_o        (pc_o),
    .push_o      (push),
    .pop_o       (pop),
    .push_data_o (push_data)
  );

  pcs_retstack #(
    .DEPTH (STACK_DEPTH),
    .AW    (PC_W)
  ) u_stack (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_o       (pop_data)
  );

  assign status_o  = status;
  assign seg_sel_o = status[ST_SEG];

  // R5: a return never disturbs the page-select bit
  a_r5_ret_keeps_page: assert property (@(posedge clk) disable iff (!rst_n_int)
    ret_i && !stat_wr_i |=> $stable(status_o[ST_PAGE]));
  // R10: segment output mirrors its status bit
  a_r10_seg_out: assert property (@(posedge clk) disable iff (!rst_n_int)
    seg_sel_o == status_o[ST_SEG]);
endmodule

// File: tb/test_pcs_paged_pc.sv
module test_pcs_paged_pc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        jmp_i, call_i, ret_i, pcl_wr_i, stat_wr_i;
  logic        sleep_i, wdtc_i, wdt_to_i;
  logic [9:0]  tgt_i;
  logic [7:0]  wdata_i;
  logic        alu_we_i, alu_z_i, alu_dc_i, alu_c_i;
  logic [10:0] pc_o;
  logic [7:0]  status_o;
  logic        seg_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pcs_paged_pc i_pcs_paged_pc (
    .clk(clk), .rst_n(rst_n), .jmp_i(jmp_i), .call_i(call_i), .ret_i(ret_i),
    .pcl_wr_i(pcl_wr_i), .stat_wr_i(stat_wr_i), .sleep_i(sleep_i),
    .wdtc_i(wdtc_i), .wdt_to_i(wdt_to_i), .tgt_i(tgt_i), .wdata_i(wdata_i),
    .alu_we_i(alu_we_i), .alu_z_i(alu_z_i), .alu_dc_i(alu_dc_i),
    .alu_c_i(alu_c_i), .pc_o(pc_o), .status_o(status_o), .seg_sel_o(seg_sel_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    jmp_i = 0; call_i = 0; ret_i = 0; pcl_wr_i = 0; stat_wr_i = 0;
    sleep_i = 0; wdtc_i = 0; wdt_to_i = 0; alu_we_i = 0;
    alu_z_i = 0; alu_dc_i = 0; alu_c_i = 0;
  endtask

  // drive one pulse cycle: inputs set by caller at a negedge, this ends it
  task automatic finish_cycle();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_reset();
    idle_inputs(); tgt_i = '0; wdata_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_jump(input logic [9:0] t);
    jmp_i = 1; tgt_i = t; finish_cycle();
  endtask

  task automatic do_stat_wr(input logic [7:0] d);
    stat_wr_i = 1; wdata_i = d; finish_cycle();
  endtask

  task automatic t_reset();
    idle_inputs(); tgt_i = '0; wdata_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc_o, 11'h000);
    chk("R1 status in reset", status_o, 8'h18);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_increment_wrap();
    logic [10:0] p;
    do_stat_wr(8'h20);
    do_jump(10'h3FD);
    chk("R2 jump start", pc_o, 11'h7FD);
    p = pc_o;
    @(negedge clk); chk("R2 increment", pc_o, p + 11'd1);
    @(negedge clk); chk("R2 at top", pc_o, 11'h7FF);
    @(negedge clk); chk("R2 wrap to zero", pc_o, 11'h000);
  endtask

  task automatic t_jump_page();
    do_stat_wr(8'h00);
    do_jump(10'h2C3);
    chk("R3 jump page0", pc_o, 11'h2C3);
    do_stat_wr(8'h20);
    do_jump(10'h2C3);
    chk("R3 jump page1", pc_o, 11'h6C3);
    call_i = 1; tgt_i = 10'h011; finish_cycle();
    chk("R3 call page1", pc_o, 11'h411);
  endtask

  task automatic t_pcl_write();
    do_stat_wr(8'h20);
    pcl_wr_i = 1; wdata_i = 8'hAB; finish_cycle();
    chk("R4 pcl write page1", pc_o, 11'h4AB);
    do_stat_wr(8'h00);
    do_jump(10'h3F0);
    pcl_wr_i = 1; wdata_i = 8'h5C; finish_cycle();
    chk("R4 pcl write clears bits 9:8", pc_o, 11'h05C);
  endtask

  task automatic t_call_return();
    do_reset();
    do_stat_wr(8'h00);
    do_jump(10'h100);
    call_i = 1; tgt_i = 10'h3A0; finish_cycle();
    chk("R5 call target", pc_o, 11'h3A0);
    do_stat_wr(8'h20);
    ret_i = 1; finish_cycle();
    chk("R5 return to caller page", pc_o, 11'h101);
    chk("R5 page bit untouched by return", status_o[5], 1'b1);
  endtask

  task automatic t_stack_depth();
    logic [10:0] saved [9];
    do_reset();
    ret_i = 1; finish_cycle();
    chk("R6 underflow after reset", pc_o, 11'h000);
    do_reset();
    do_stat_wr(8'h00);
    do_jump(10'h200);
    for (int i = 0; i < 9; i++) begin
      saved[i] = pc_o + 11'd1;
      call_i = 1; tgt_i = 10'(10'h040 + i * 8); finish_cycle();
    end
    for (int k = 8; k >= 1; k--) begin
      ret_i = 1; finish_cycle();
      chk("R6 overflow pop order", pc_o, saved[k]);
    end
    ret_i = 1; finish_cycle();
    chk("R6 underflow wraps", pc_o, saved[8]);
  endtask

  task automatic t_priority();
    do_reset();
    do_stat_wr(8'h00);
    do_jump(10'h050);
    call_i = 1; tgt_i = 10'h300; finish_cycle();
    ret_i = 1; call_i = 1; jmp_i = 1; pcl_wr_i = 1; tgt_i = 10'h3FF; wdata_i = 8'h77;
    finish_cycle();
    chk("R7 return wins", pc_o, 11'h051);
    ret_i = 1; finish_cycle();
    chk("R7 losing call pushed nothing", pc_o, 11'h000);
    do_jump(10'h020);
    call_i = 1; pcl_wr_i = 1; tgt_i = 10'h155; wdata_i = 8'h99; finish_cycle();
    chk("R7 call beats pcl write", pc_o, 11'h155);
    ret_i = 1; finish_cycle();
    chk("R7 call pushed", pc_o, 11'h021);
    jmp_i = 1; pcl_wr_i = 1; tgt_i = 10'h1E0; wdata_i = 8'h12; finish_cycle();
    chk("R7 jump beats pcl write", pc_o, 11'h1E0);
  endtask

  task automatic t_flags();
    do_reset();
    sleep_i = 1; finish_cycle();
    chk("R8 R9 sleep", status_o, 8'h10);
    wdt_to_i = 1; finish_cycle();
    chk("R8 timeout clears", status_o, 8'h00);
    wdtc_i = 1; finish_cycle();
    chk("R8 R9 watchdog clear", status_o, 8'h18);
    wdt_to_i = 1; wdtc_i = 1; finish_cycle();
    chk("R8 timeout beats clear", status_o, 8'h08);
    sleep_i = 1; wdtc_i = 1; finish_cycle();
    chk("R9 clear beats sleep", status_o, 8'h18);
    sleep_i = 1; wdt_to_i = 1; finish_cycle();
    chk("R8 timeout beats sleep", status_o, 8'h00);
  endtask

  task automatic t_status_write();
    do_stat_wr(8'hFF);
    chk("R10 write skips bits 4:3", status_o, 8'hE7);
    chk("R10 segment output", seg_sel_o, 1'b1);
    wdtc_i = 1; finish_cycle();
    do_stat_wr(8'h00);
    chk("R10 write keeps set bits 4:3", status_o, 8'h18);
    chk("R10 segment output low", seg_sel_o, 1'b0);
  endtask

  task automatic t_alu();
    alu_we_i = 1; alu_z_i = 1; alu_dc_i = 0; alu_c_i = 1; finish_cycle();
    chk("R11 alu flags", status_o[2:0], 3'b101);
    alu_we_i = 1; alu_z_i = 1; alu_dc_i = 1; alu_c_i = 1;
    stat_wr_i = 1; wdata_i = 8'h02; finish_cycle();
    chk("R11 write wins over alu", status_o[2:0], 3'b010);
  endtask

  task automatic t_page_timing();
    do_stat_wr(8'h00);
    stat_wr_i = 1; wdata_i = 8'h20; jmp_i = 1; tgt_i = 10'h123; finish_cycle();
    chk("R12 old page used", pc_o, 11'h123);
    chk("R12 page written", status_o[5], 1'b1);
    do_jump(10'h123);
    chk("R12 new page next", pc_o, 11'h523);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_increment_wrap();
    t_jump_page();
    t_pcl_write();
    t_call_return();
    t_stack_depth();
    t_priority();
    t_flags();
    t_status_write();
    t_alu();
    t_page_timing();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule